// File: doc/BRIEF.md
# Soft Reset Control Register

This block is a single memory-mapped control register that lets software put the core logic of a USB controller through a soft reset and then learn when that reset has finished. Software sets a request bit and the block drives a reset output to the core for a fixed number of clock cycles. A counter measures that duration. The register also carries two read-only status bits: one shows that the bus master is idle, and one mirrors a DMA request from the core.

How completion is shown depends on a revision parameter, whose low 16 bits are compared against 0x420A. For older revisions, hardware clears the request bit when the reset ends, and software polls for that bit to read 0. For revision 0x420A and later, the request bit stays set after completion and a sticky done flag is raised. Software then acknowledges with one write that clears the request bit and writes 1 to the done bit.

Top module: `srst_ctrl_reg`

## Requirements
- R1: After reset, `core_srst` is 0, and the register reads with bit 0 (request) = 0 and bit 29 (done) = 0.
- R2: The register answers only at byte address 0x010. A read at any other address returns 0, and a write to any other address changes nothing. Read data for a read enabled at clock edge N appears on `bus_rdata` after edge N and holds until the next read.
- R3: Writing 1 to bit 0 while bit 0 reads 0 starts a reset. `core_srst` goes high after the write's clock edge and stays high for exactly RST_CYCLES cycles.
- R4: With a revision below 0x420A, bit 0 reads 1 while the reset runs and is cleared by hardware when the reset completes. Bit 29 always reads 0 in this mode.
- R5: With a revision of 0x420A or later, bit 0 still reads 1 when the reset completes, and bit 29 is set at that moment.
- R6: The done flag is sticky. Writing 1 to bit 29 clears it, and writing 0 to bit 29 leaves it set. A single write of 0x2000_0000 after completion clears both bit 0 and bit 29.
- R7: Writing 1 to bit 0 while bit 0 already reads 1 starts no new reset. A write of 0 to bit 0 while a reset is still running is ignored.
- R8: A new reset request clears a done flag left over from an earlier reset. Bit 29 reads 0 while the new reset runs.
- R9: Bit 31 reads 1 whenever `xfer_active` is 0 or a reset is running. Bit 30 mirrors `dma_req`.
- R10: If a write of 1 to bit 29 falls on the same clock edge as the completion of a reset, completion wins. The done flag ends up set and bit 0 stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_re | input | 1 | Read enable, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| xfer_active | input | 1 | Core reports a bus-master transfer in progress |
| dma_req | input | 1 | Core DMA request status |
| core_srst | output | 1 | Soft reset to the core logic, active high |

## Verification
Two events can land on the same clock edge: the reset counter expiring, and a software write to the register. The bench provokes this by counting cycles from the starting write so that a second write reaches the exact completion edge. In the newer mode, that second write is a done acknowledge. The bench then expects the done flag to be set and bit 0 to still be 1 (R10). In the legacy mode, the second write is a fresh request of 1. The bench then expects the request bit to be cleared by hardware and no second pulse on `core_srst` (R7).

// File: rtl/srst_pkg.sv
package srst_pkg;
  localparam int REG_BYTE_OFS  = 'h010;
  localparam int BIT_REQ       = 0;
  localparam int BIT_DONE      = 29;
  localparam int BIT_DMA       = 30;
  localparam int BIT_IDLE      = 31;
  localparam int WORD_W        = 32;
  localparam logic [15:0] REV_STICKY_DONE = 16'h420A;
endpackage

// File: rtl/srst_timer.sv
module srst_timer #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic last
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_en;

  assign last = busy_q && (cnt_q == '0);
  assign busy = busy_q;

  always_comb begin
    cnt_en = load || busy_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load) begin
      cnt_d  = LOAD_VAL;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/srst_seq.sv
module srst_seq #(
  parameter bit NEW_FLOW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_req,
  input  logic wr_ack,
  input  logic busy,
  input  logic last,
  output logic start,
  output logic req,
  output logic done
);
  logic req_q, req_d;

  assign start = wr_hit && wr_req && !req_q;
  assign req   = req_q;

  always_comb begin
    req_d = req_q;
    if (start)              req_d = 1'b1;
    else if (last)          req_d = NEW_FLOW;
    else if (wr_hit && !busy) req_d = wr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  generate
    if (NEW_FLOW) begin : g_sticky
      logic done_q, done_d, done_en;
      always_comb begin
        done_en = start || last || (wr_hit && wr_ack);
        done_d  = done_q;
        if (start)                done_d = 1'b0;
        else if (last)            done_d = 1'b1;
        else if (wr_hit && wr_ack) done_d = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       done_q <= 1'b0;
        else if (done_en) done_q <= done_d;
      end
      assign done = done_q;
    end else begin : g_selfclear
      assign done = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/srst_regif.sv
module srst_regif
  import srst_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              req,
  input  logic              done,
  input  logic              idle,
  input  logic              dma_req,
  output logic              wr_hit,
  output logic [WORD_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_BYTE_OFS);

  logic              sel;
  logic [WORD_W-1:0] word, rdata_q, rdata_d;

  assign sel    = (bus_addr == MY_ADDR);
  assign wr_hit = bus_we && sel;

  always_comb begin
    word           = '0;
    word[BIT_REQ]  = req;
    word[BIT_DONE] = done;
    word[BIT_DMA]  = dma_req;
    word[BIT_IDLE] = idle;
    rdata_d        = sel ? word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_re) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/srst_ctrl_reg.sv
module srst_ctrl_reg
  import srst_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          RST_CYCLES = 8,
  parameter logic [15:0] CORE_REV   = 16'h420A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic              xfer_active,
  input  logic              dma_req,
  output logic              core_srst
);
  localparam bit NEW_FLOW = (CORE_REV >= REV_STICKY_DONE);

  logic wr_hit, start, busy, last, req, done, idle;

  assign idle      = busy || !xfer_active;
  assign core_srst = busy;

  srst_regif #(.ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .req(req), .done(done), .idle(idle),
    .dma_req(dma_req), .wr_hit(wr_hit), .bus_rdata(bus_rdata)
  );

  srst_seq #(.NEW_FLOW(NEW_FLOW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
    .wr_req(bus_wdata[BIT_REQ]), .wr_ack(bus_wdata[BIT_DONE]),
    .busy(busy), .last(last), .start(start), .req(req), .done(done)
  );

  srst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start), .busy(busy), .last(last)
  );
endmodule

// File: rtl/srst_ctrl_chk.sv
module srst_ctrl_chk #(
  parameter int RST_CYCLES = 8,
  parameter bit NEW_FLOW   = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic core_srst,
  input logic req,
  input logic done,
  input logic start,
  input logic wr_hit,
  input logic wr_ack
);
  localparam int HW = $clog2(RST_CYCLES + 1) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= '0;
    else if (core_srst) hi_cnt <= hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  p_pulse_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_srst |-> (int'(hi_cnt) < RST_CYCLES));
  p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_srst && hi_cnt != '0) |-> (int'(hi_cnt) == RST_CYCLES));
  p_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!NEW_FLOW && $fell(core_srst)) |-> !req);
  p_no_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !NEW_FLOW |-> !done);
  p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (NEW_FLOW && $fell(core_srst)) |-> (done && req));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && !(wr_hit && wr_ack)) |=> done);
  p_no_retrigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_srst) |-> !$past(req));
  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_srst |-> req);
  p_stale_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_srst) |-> !done);
endmodule

bind srst_ctrl_reg srst_ctrl_chk #(.RST_CYCLES(RST_CYCLES), .NEW_FLOW(NEW_FLOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_srst(core_srst), .req(req), .done(done),
  .start(start), .wr_hit(wr_hit), .wr_ack(bus_wdata[29])
);

// File: tb/sim_srst_ctrl_reg.sv
`timescale 1ns/1ps
module sim_srst_ctrl_reg;
  localparam int RST = 6;

  logic        clk, rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        we0, we1, bus_re, xfer_active, dma_req;
  logic [31:0] rdata0, rdata1;
  logic        srst0, srst1;
  logic        pend;
  int          n_chk, n_fail;
  bit          done_flag;

  typedef struct { int inst; logic [31:0] exp; string tag; } item_t;
  item_t sq[$];

  srst_ctrl_reg #(.ADDR_W(12), .RST_CYCLES(RST), .CORE_REV(16'h420A)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(we0), .bus_re(bus_re), .bus_rdata(rdata0),
    .xfer_active(xfer_active), .dma_req(dma_req), .core_srst(srst0));

  srst_ctrl_reg #(.ADDR_W(12), .RST_CYCLES(RST), .CORE_REV(16'h400A)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(we1), .bus_re(bus_re), .bus_rdata(rdata1),
    .xfer_active(xfer_active), .dma_req(dma_req), .core_srst(srst1));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) pend <= bus_re;

  always @(negedge clk) begin
    if (pend && sq.size() > 0) begin
      item_t e;
      logic [31:0] act;
      e = sq.pop_front();
      act = (e.inst == 0) ? rdata0 : rdata1;
      chk(act === e.exp, e.tag, act, e.exp);
    end
  end

  task automatic wr(input int inst, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    if (inst == 0) we0 = 1'b1; else we1 = 1'b1;
    @(negedge clk);
    we0 = 1'b0; we1 = 1'b0;
  endtask

  task automatic rd(input int inst, input logic [11:0] a, input logic [31:0] exp, input string tag);
    item_t e;
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    e.inst = inst; e.exp = exp; e.tag = tag;
    sq.push_back(e);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wait_low(input int inst);
    if (inst == 0) while (srst0) @(negedge clk);
    else           while (srst1) @(negedge clk);
  endtask

  task automatic quiet(input int inst, input string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(((inst == 0) ? srst0 : srst1) == 1'b0, tag,
          32'((inst == 0) ? srst0 : srst1), 32'h0);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    int n;
    n_chk = 0; n_fail = 0; done_flag = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; we0 = 0; we1 = 0; bus_re = 0;
    xfer_active = 1'b0; dma_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    chk(srst0 == 1'b0 && srst1 == 1'b0, "R1 core_srst low after reset", {srst0, srst1}, 32'h0);
    rd(0, 12'h010, 32'h8000_0000, "R1 reset value new mode");
    rd(1, 12'h010, 32'h8000_0000, "R1 reset value legacy mode");
    rd(0, 12'h014, 32'h0, "R2 other address reads 0");
    wr(0, 12'h014, 32'h2000_0001);
    quiet(0, "R2 write to other address starts nothing");
    rd(0, 12'h010, 32'h8000_0000, "R2 register unchanged");

    // legacy pulse length and self clearing
    wr(1, 12'h010, 32'h1);
    n = 0;
    while (srst1) begin n++; @(negedge clk); end
    chk(n == RST, "R3 pulse length", n, RST);
    rd(1, 12'h010, 32'h8000_0000, "R4 request self-cleared");
    wr(1, 12'h010, 32'h2000_0001);
    rd(1, 12'h010, 32'h8000_0001, "R4 request reads 1 during reset");
    wait_low(1);
    rd(1, 12'h010, 32'h8000_0000, "R4 no done flag in legacy mode");

    // legacy: fresh request exactly on the completion edge
    wr(1, 12'h010, 32'h1);
    repeat (RST - 2) @(negedge clk);
    wr(1, 12'h010, 32'h1);
    quiet(1, "R7 request on completion edge starts nothing");
    rd(1, 12'h010, 32'h8000_0000, "R7 legacy request cleared after collision");

    // new flow
    xfer_active = 1'b1;
    wr(0, 12'h010, 32'h1);
    wr(0, 12'h010, 32'h0);
    rd(0, 12'h010, 32'h8000_0001, "R9 R7 idle during reset, clear ignored");
    wait_low(0);
    rd(0, 12'h010, 32'h2000_0001, "R5 done set, request held");
    wr(0, 12'h010, 32'h1);
    quiet(0, "R7 request already set starts nothing");
    rd(0, 12'h010, 32'h2000_0001, "R7 state held");
    wr(0, 12'h010, 32'h0);
    rd(0, 12'h010, 32'h2000_0000, "R6 writing 0 to done keeps it");
    wr(0, 12'h010, 32'h1);
    rd(0, 12'h010, 32'h8000_0001, "R8 stale done cleared by new request");
    wait_low(0);
    rd(0, 12'h010, 32'h2000_0001, "R5 done after second reset");
    wr(0, 12'h010, 32'h2000_0000);
    rd(0, 12'h010, 32'h0000_0000, "R6 acknowledge clears request and done");
    dma_req = 1'b1;
    rd(0, 12'h010, 32'h4000_0000, "R9 dma status mirrored");
    dma_req = 1'b0;

    // acknowledge on the completion edge
    wr(0, 12'h010, 32'h1);
    repeat (RST - 2) @(negedge clk);
    wr(0, 12'h010, 32'h2000_0000);
    chk(srst0 == 1'b0, "R10 reset ended on collision edge", srst0, 32'h0);
    rd(0, 12'h010, 32'h2000_0001, "R10 completion wins over acknowledge");
    wr(0, 12'h010, 32'h2000_0000);
    xfer_active = 1'b0;
    rd(0, 12'h010, 32'h8000_0000, "R9 idle when no transfer");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule